// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps the contents of an asynchronous DRAM alive. Out of reset it holds the row and column strobes inactive for the power-up settling time. It then runs a fixed number of warm-up strobe cycles on its own and raises a ready flag. Normal traffic must not start before that flag is high. From then on, an interval timer produces one refresh obligation per slot. Each slot is the retention window divided by the number of rows, converted to clock cycles and rounded down.

Every refresh is a CAS-before-RAS cycle, so the memory's internal row counter picks the row and no address is driven. The order in which rows are refreshed does not matter. The access controller owning the DRAM pins arbitrates through a request/grant pair that works like valid/ready. `ref_req` is the valid side. Once raised, it stays high and unchanged until a clock edge where `ref_gnt` is also high. That edge is the transfer, and the block drives the strobes itself from the next cycle.

The controller may hold off the grant for as long as it likes. Refreshes that are not served then accumulate in a saturating backlog. When the backlog is full, `ref_urgent` tells the controller to give refresh priority. All widths and times derive from the parameters `CLK_MHZ`, `PWRUP_US`, `RETENTION_US`, `ROWS`, `INIT_CYCLES`, `T_CSR`, `T_RAS`, `T_RP` and `PEND_MAX`.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and during the power-up wait, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, and `init_done` and `ref_req` are 0.
- R2: The first CAS fall comes no earlier than PWR_CYC = PWRUP_US*CLK_MHZ cycles after reset is released, and no later than PWR_CYC+2 cycles after.
- R3: Exactly INIT_CYCLES RAS pulses occur before `init_done` rises. `ref_req` stays 0 until then, and `init_done` stays 1 once set.
- R4: In every strobe cycle CAS falls while RAS is high, RAS falls exactly T_CSR cycles later, and `dram_we_n` is 1 throughout.
- R5: RAS stays low for exactly T_RAS cycles. RAS and CAS rise in the same cycle, and both stay high for at least T_RP cycles before the next CAS fall.
- R6: Refresh slots recur every INTERVAL = floor(RETENTION_US*CLK_MHZ/ROWS) cycles. The first `ref_req` rises INTERVAL cycles after `init_done` rises.
- R7: Once raised, `ref_req` holds until a cycle with `ref_gnt` high. CAS falls in the cycle after that transfer, and `ref_req` is low while the refresh runs.
- R8: Each slot that expires without service adds one to the backlog, which saturates at PEND_MAX. `ref_urgent` is 1 exactly while the backlog is at PEND_MAX.
- R9: With the grant held high, a backlog of N drains as exactly N refresh cycles and no more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; also marks power application |
| ref_req | output | 1 | Refresh wanted (valid side of the handshake) |
| ref_gnt | input | 1 | Access controller hands over the DRAM pins (ready side) |
| ref_urgent | output | 1 | Backlog full; refresh must be given priority |
| init_done | output | 1 | Power-up sequence finished; normal traffic allowed |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, held high |

## Verification
The hardest state to reach from the ports is a saturated backlog that then drains, because it only arises when the controller withholds the grant across several slots. The bench withholds `ref_gnt` until `ref_urgent` rises, checks how long that took, and keeps withholding for two more slots to show the count does not grow. It then grants continuously and counts the RAS pulses. A separate sweep of grant latencies from zero to five cycles shows that the request holds and that the slot period does not drift with the delay.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    PH_PWR,
    PH_INIT,
    PH_RUN
  } phase_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CSET,
    SQ_ACT,
    SQ_PRE
  } seq_e;

  function automatic int cw(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/cbr_sequencer.sv
module cbr_sequencer
  import dram_ref_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_RAS = 5,
  parameter int T_RP  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);

  localparam int MAXT = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                        : ((T_RAS > T_RP) ? T_RAS : T_RP);
  localparam int CW = cw(MAXT);

  seq_e          st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st  <= SQ_CSET;
          cnt <= CW'(T_CSR - 1);
        end
        SQ_CSET: if (cnt == '0) begin
          st  <= SQ_ACT;
          cnt <= CW'(T_RAS - 1);
        end else cnt <= cnt - 1'b1;
        SQ_ACT: if (cnt == '0) begin
          st  <= SQ_PRE;
          cnt <= CW'(T_RP - 1);
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          st <= SQ_IDLE;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign busy  = (st != SQ_IDLE);
  assign done  = (st == SQ_PRE) && (cnt == '0);
  assign ras_n = (st != SQ_ACT);
  assign cas_n = !((st == SQ_CSET) || (st == SQ_ACT));

  // CAS must lead RAS low and stay low beneath it
  assert_ras_under_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));
  assert_joint_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $rose(cas_n));
  assert_start_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/ref_tick_timer.sv
module ref_tick_timer
  import dram_ref_pkg::*;
#(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int TW = cw(INTERVAL);

  logic [TW-1:0] cnt;

  assign tick = en && (cnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  generate
    if (INTERVAL > 1) begin : g_spacing
      assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/ref_backlog.sv
module ref_backlog
  import dram_ref_pkg::*;
#(
  parameter int PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic any,
  output logic urgent
);

  localparam int PW = cw(PEND_MAX + 1);

  logic [PW-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else begin
      case ({tick, take})
        2'b10:   if (pend != PW'(PEND_MAX)) pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  assign any    = (pend != '0);
  assign urgent = (pend == PW'(PEND_MAX));

  assert_backlog_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(PEND_MAX));
  assert_take_needs_work_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> any);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int PWRUP_US     = 200,
  parameter int RETENTION_US = 32000,
  parameter int ROWS         = 2048,
  parameter int INIT_CYCLES  = 8,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 5,
  parameter int T_RP         = 3,
  parameter int PEND_MAX     = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_req,
  input  logic ref_gnt,
  output logic ref_urgent,
  output logic init_done,
  output logic dram_ras_n,
  output logic dram_cas_n,
  output logic dram_we_n
);

  localparam int PWR_CYC  = PWRUP_US * CLK_MHZ;
  localparam int INTERVAL = (RETENTION_US * CLK_MHZ) / ROWS;
  localparam int PCW      = cw(PWR_CYC);
  localparam int ICW      = cw(INIT_CYCLES);

  phase_e         phase;
  logic [PCW-1:0] pwr_cnt;
  logic [ICW-1:0] init_cnt;
  logic           seq_busy, seq_done, seq_start;
  logic           tick, pend_any, accept;

  assign accept    = ref_req && ref_gnt;
  assign seq_start = ((phase == PH_INIT) && !seq_busy) || accept;
  assign ref_req   = (phase == PH_RUN) && pend_any && !seq_busy;
  assign init_done = (phase == PH_RUN);
  assign dram_we_n = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_PWR;
      pwr_cnt  <= '0;
      init_cnt <= '0;
    end else begin
      case (phase)
        PH_PWR: begin
          if (pwr_cnt == PCW'(PWR_CYC - 1)) phase <= PH_INIT;
          else                              pwr_cnt <= pwr_cnt + 1'b1;
        end
        PH_INIT: begin
          if (seq_done) begin
            if (init_cnt == ICW'(INIT_CYCLES - 1)) phase <= PH_RUN;
            else                                   init_cnt <= init_cnt + 1'b1;
          end
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  ref_tick_timer #(.INTERVAL(INTERVAL)) timer_i (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_RUN), .tick(tick)
  );

  ref_backlog #(.PEND_MAX(PEND_MAX)) backlog_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .take(accept),
    .any(pend_any), .urgent(ref_urgent)
  );

  cbr_sequencer #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .busy(seq_busy),
    .done(seq_done), .ras_n(dram_ras_n), .cas_n(dram_cas_n)
  );

  assert_quiet_powerup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PWR) |-> (dram_ras_n && dram_cas_n));
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);
  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  assert_grant_launches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !dram_cas_n);

endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;

  localparam int CLK_PERIOD   = 10;
  localparam int CLK_MHZ      = 1;
  localparam int PWRUP_US     = 20;
  localparam int RETENTION_US = 256;
  localparam int ROWS         = 4;
  localparam int INIT_CYCLES  = 8;
  localparam int T_CSR        = 2;
  localparam int T_RAS        = 3;
  localparam int T_RP         = 2;
  localparam int PEND_MAX     = 3;
  localparam int PWR_CYC      = PWRUP_US * CLK_MHZ;
  localparam int INTERVAL     = (RETENTION_US * CLK_MHZ) / ROWS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_urgent, init_done, dram_ras_n, dram_cas_n, dram_we_n;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_sched #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .RETENTION_US(RETENTION_US),
    .ROWS(ROWS), .INIT_CYCLES(INIT_CYCLES), .T_CSR(T_CSR), .T_RAS(T_RAS),
    .T_RP(T_RP), .PEND_MAX(PEND_MAX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .ref_urgent(ref_urgent), .init_done(init_done), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe waveform monitor, sampled mid-cycle
  int  ras_falls = 0;
  bit  prev_ras = 1'b1, prev_cas = 1'b1, have_rise = 1'b0;
  int  cas_fall_c = 0, ras_fall_c = 0, rise_c = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras  <= 1'b1;
      prev_cas  <= 1'b1;
      have_rise <= 1'b0;
    end else begin
      if (prev_cas && !dram_cas_n) begin
        check(dram_ras_n == 1'b1, "R4 ras high at cas fall", int'(dram_ras_n), 1);
        check(dram_we_n == 1'b1, "R4 we high", int'(dram_we_n), 1);
        if (have_rise)
          check(cyc - rise_c >= T_RP, "R5 precharge", cyc - rise_c, T_RP);
        cas_fall_c <= cyc;
      end
      if (prev_ras && !dram_ras_n) begin
        check(cyc - cas_fall_c == T_CSR, "R4 cas-to-ras", cyc - cas_fall_c, T_CSR);
        ras_fall_c <= cyc;
        ras_falls  <= ras_falls + 1;
      end
      if (!prev_ras && dram_ras_n) begin
        check(cyc - ras_fall_c == T_RAS, "R5 ras width", cyc - ras_fall_c, T_RAS);
        check(!prev_cas && dram_cas_n, "R5 joint rise", int'(dram_cas_n), 1);
        rise_c    <= cyc;
        have_rise <= 1'b1;
      end
      prev_ras <= dram_ras_n;
      prev_cas <= dram_cas_n;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int k, t0, bad, rr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset",
          int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
    check(!init_done && !ref_req, "R1 flags in reset", int'({init_done, ref_req}), 0);

    rst_n = 1'b1;
    ras_falls = 0;
    k = 0; bad = 0;
    while (k < PWR_CYC + 10) begin
      @(negedge clk);
      k++;
      if (!dram_cas_n) break;
      if (!dram_ras_n || !dram_we_n || init_done || ref_req) bad++;
    end
    check(bad == 0, "R1 quiet power-up", bad, 0);
    check(k >= PWR_CYC && k <= PWR_CYC + 2, "R2 first activity", k, PWR_CYC + 1);

    bad = 0; k = 0;
    while (!init_done && k < 1000) begin
      @(negedge clk);
      k++;
      if (ref_req) bad++;
    end
    check(bad == 0, "R3 no req before ready", bad, 0);
    check(ras_falls == INIT_CYCLES, "R3 init pulses", ras_falls, INIT_CYCLES);
    t0 = cyc;

    k = 0;
    while (!ref_req && k < 10 * INTERVAL) begin @(negedge clk); k++; end
    check(cyc - t0 == INTERVAL, "R6 first slot", cyc - t0, INTERVAL);
    check(init_done, "R3 ready sticky", int'(init_done), 1);

    // R7/R6: sweep grant latency
    for (int lat = 0; lat < 6; lat++) begin
      rr = cyc; bad = 0;
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        if (!ref_req) bad++;
      end
      check(bad == 0, "R7 req held", bad, 0);
      ref_gnt = 1'b1;
      @(negedge clk);
      ref_gnt = 1'b0;
      check(!dram_cas_n, "R7 cas after grant", int'(dram_cas_n), 0);
      check(!ref_req, "R7 req low while busy", int'(ref_req), 0);
      k = 0;
      while (!ref_req && k < 10 * INTERVAL) begin @(negedge clk); k++; end
      check(cyc - rr == INTERVAL, "R6 slot period", cyc - rr, INTERVAL);
    end

    // R8: backlog fills while grant is withheld
    rr = cyc;
    check(!ref_urgent, "R8 not urgent at one", int'(ref_urgent), 0);
    k = 0;
    while (!ref_urgent && k < 10 * INTERVAL) begin @(negedge clk); k++; end
    check(cyc - rr == (PEND_MAX - 1) * INTERVAL, "R8 urgent timing",
          cyc - rr, (PEND_MAX - 1) * INTERVAL);
    bad = 0;
    for (int w = 0; w < 2 * INTERVAL + 2; w++) begin
      @(negedge clk);
      if (!ref_urgent || !ref_req) bad++;
    end
    check(bad == 0, "R8 saturated and held", bad, 0);

    // R9: drain
    ras_falls = 0;
    ref_gnt = 1'b1;
    @(negedge clk);
    check(!ref_urgent, "R8 urgent clears on grant", int'(ref_urgent), 0);
    repeat (40) @(negedge clk);
    ref_gnt = 1'b0;
    check(ras_falls == PEND_MAX, "R9 drain count", ras_falls, PEND_MAX);
    check(!ref_req, "R9 nothing left", int'(ref_req), 0);

    // R1: reset during operation
    rst_n = 1'b0;
    @(negedge clk);
    check(dram_ras_n && dram_cas_n && !init_done && !ref_req && !ref_urgent,
          "R1 mid-run reset", int'({dram_ras_n, dram_cas_n, init_done, ref_req}), 12);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule